// File: doc/BRIEF.md
# Deferred Transaction Tracking Queue

This block sits on the requesting side of a split-transaction bus. When one of the requester's own transactions ends its response phase with a Deferred response, the requester pushes the transaction's ID and kind (read or write) into the queue. The entry then waits for the responding agent to start a Deferred Reply transaction of its own. The entry is retired when that reply arrives, and not in the order in which entries were created.

The queue watches the request phase of every Deferred Reply on the bus. It splits the reply's 8-bit deferred-ID field into agent type, agent ID and transaction ID. If the agent type and agent ID are this requester's own identity and the transaction ID names a live entry, it reports a match. When the reply's response phase completes, the matched entry is retired. The requester then gets a completion pulse, which carries the entry's transaction ID, its kind and whether the response means success. Entries are stored in a table indexed directly by transaction ID. A transaction ID already in use is therefore refused with an error pulse.

Top module: `dtq_tracker`

## Requirements
- R1: After reset, `q_empty` is 1 and `q_full`, `match_valid`, `done_valid` and `dup_err` are 0.
- R2: An enqueue (`enq_valid` high for one cycle) on a free transaction ID records that ID and its kind (0 = write, 1 = read). From the next cycle on, `q_empty` reads 0.
- R3: An enqueue whose transaction ID is already live pulses `dup_err` in the next cycle. The entry that is already live keeps its kind, which a later completion reports.
- R4: The deferred-ID field is laid out as bit 7 = agent type, bits 6:3 = agent ID and bits 2:0 = transaction ID. A reply request matches only when all three parts equal a live entry together with the own identity inputs. On a match, `match_valid` pulses with `match_tid` in the cycle after `reply_req_valid`.
- R5: A response phase (`reply_rsp_valid`) that follows a matched request retires the entry. In the next cycle `done_valid` pulses with `done_tid` and `done_kind` of that entry.
- R6: Response code 2'b00 (no data) gives `done_ok` = 1.
- R7: Any other response code, including hard failure (2'b01), gives `done_ok` = 0. The entry is still retired.
- R8: A reply request that matches no entry, whether because of a foreign agent type, a foreign agent ID or a free transaction ID, is ignored. It gives no `match_valid`, and its response phase gives no `done_valid` and changes no entry.
- R9: A response phase that is not preceded by a matched request produces no `done_valid` and changes no entry.
- R10: `q_full` is 1 exactly when all 8 entries are live, and `q_empty` is 1 exactly when none are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| own_agent_type | input | 1 | Agent type of this requester |
| own_agent_id | input | 4 | Agent ID of this requester |
| enq_valid | input | 1 | A transaction of this requester received a Deferred response |
| enq_tid | input | 3 | Transaction ID of the deferred transaction |
| enq_kind | input | 1 | Kind of the deferred transaction: 0 = write, 1 = read |
| reply_req_valid | input | 1 | Request phase of a Deferred Reply observed |
| reply_defid | input | 8 | Deferred-ID field of the reply |
| reply_rsp_valid | input | 1 | Response phase of the reply completes |
| reply_rsp_code | input | 2 | Response code of the reply |
| match_valid | output | 1 | The reply request matched a live entry |
| match_tid | output | 3 | Transaction ID of the matched entry |
| done_valid | output | 1 | An entry was retired |
| done_ok | output | 1 | 1 = success, 0 = failure |
| done_tid | output | 3 | Transaction ID of the retired entry |
| done_kind | output | 1 | Kind of the retired entry |
| dup_err | output | 1 | The enqueue was refused because its ID is already live |
| q_full | output | 1 | All entries live |
| q_empty | output | 1 | No entry live |

## Verification
`dup_err`, `match_valid` and `done_valid` with their fields are registered. Each is due exactly one clock after its stimulus, and each is high only during that cycle. `q_full` and `q_empty` follow the entry table, which an enqueue or a retirement updates at that same edge. The bench drives every stimulus on a falling edge and removes it on the next falling edge. At that point it samples the pulses and the fill flags, so each check reads the cycle in which its result is due.

// File: rtl/dtq_pkg.sv
package dtq_pkg;

    localparam int DTQ_DEPTH_DEF      = 8;
    localparam int DTQ_AGENT_ID_W_DEF = 4;

    typedef enum logic [1:0] {
        RSP_NODATA   = 2'b00,
        RSP_HARDFAIL = 2'b01,
        RSP_DATA     = 2'b10,
        RSP_RSVD     = 2'b11
    } rsp_code_e;

    typedef enum logic {
        KIND_WRITE = 1'b0,
        KIND_READ  = 1'b1
    } txn_kind_e;

    typedef struct packed {
        logic      live;
        txn_kind_e kind;
    } entry_t;

    function automatic logic rsp_is_success(input logic [1:0] code);
        return code == RSP_NODATA;
    endfunction

endpackage

// File: rtl/dtq_id_match.sv
module dtq_id_match #(
    parameter int AGENT_ID_W = 4,
    parameter int TID_W      = 3,
    localparam int DEFID_W   = 1 + AGENT_ID_W + TID_W
) (
    input  logic                  own_agent_type,
    input  logic [AGENT_ID_W-1:0] own_agent_id,
    input  logic [DEFID_W-1:0]    defid,
    output logic                  owner_hit,
    output logic [TID_W-1:0]      tid
);
    logic                  f_type;
    logic [AGENT_ID_W-1:0] f_agent;

    always_comb begin
        f_type    = defid[DEFID_W-1];
        f_agent   = defid[DEFID_W-2 -: AGENT_ID_W];
        tid       = defid[TID_W-1:0];
        owner_hit = (f_type == own_agent_type) && (f_agent == own_agent_id);
    end
endmodule

// File: rtl/dtq_entry_table.sv
module dtq_entry_table
    import dtq_pkg::*;
#(
    parameter int DEPTH  = 8,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             set_en,
    input  logic [IDX_W-1:0] set_idx,
    input  logic             set_kind,
    input  logic             clr_en,
    input  logic [IDX_W-1:0] clr_idx,
    output logic [DEPTH-1:0] live_vec,
    output logic [DEPTH-1:0] kind_vec
);
    entry_t slot_q [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                slot_q[i] <= '{live: 1'b0, kind: KIND_WRITE};
            end else if (set_en && (set_idx == IDX_W'(i))) begin
                slot_q[i] <= '{live: 1'b1, kind: txn_kind_e'(set_kind)};
            end else if (clr_en && (clr_idx == IDX_W'(i))) begin
                slot_q[i].live <= 1'b0;
            end
        end
        assign live_vec[i] = slot_q[i].live;
        assign kind_vec[i] = slot_q[i].kind;
    end
endmodule

// File: rtl/dtq_tracker.sv
module dtq_tracker
    import dtq_pkg::*;
#(
    parameter int DEPTH      = DTQ_DEPTH_DEF,
    parameter int AGENT_ID_W = DTQ_AGENT_ID_W_DEF,
    localparam int TID_W     = $clog2(DEPTH),
    localparam int DEFID_W   = 1 + AGENT_ID_W + TID_W
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  own_agent_type,
    input  logic [AGENT_ID_W-1:0] own_agent_id,
    input  logic                  enq_valid,
    input  logic [TID_W-1:0]      enq_tid,
    input  logic                  enq_kind,
    input  logic                  reply_req_valid,
    input  logic [DEFID_W-1:0]    reply_defid,
    input  logic                  reply_rsp_valid,
    input  logic [1:0]            reply_rsp_code,
    output logic                  match_valid,
    output logic [TID_W-1:0]      match_tid,
    output logic                  done_valid,
    output logic                  done_ok,
    output logic [TID_W-1:0]      done_tid,
    output logic                  done_kind,
    output logic                  dup_err,
    output logic                  q_full,
    output logic                  q_empty
);
    logic [DEPTH-1:0] live_vec;
    logic [DEPTH-1:0] kind_vec;
    logic             owner_hit;
    logic [TID_W-1:0] reply_tid;
    logic             enq_dup;
    logic             enq_take;
    logic             req_hit;
    logic             retire;
    logic             pend_q;
    logic [TID_W-1:0] pend_tid_q;

    dtq_id_match #(.AGENT_ID_W(AGENT_ID_W), .TID_W(TID_W)) u_match (
        .own_agent_type (own_agent_type),
        .own_agent_id   (own_agent_id),
        .defid          (reply_defid),
        .owner_hit      (owner_hit),
        .tid            (reply_tid)
    );

    always_comb begin
        enq_dup  = enq_valid && live_vec[enq_tid];
        enq_take = enq_valid && !live_vec[enq_tid];
        req_hit  = reply_req_valid && owner_hit && live_vec[reply_tid];
        retire   = reply_rsp_valid && pend_q;
    end

    dtq_entry_table #(.DEPTH(DEPTH)) u_table (
        .clk      (clk),
        .rst      (rst),
        .set_en   (enq_take),
        .set_idx  (enq_tid),
        .set_kind (enq_kind),
        .clr_en   (retire),
        .clr_idx  (pend_tid_q),
        .live_vec (live_vec),
        .kind_vec (kind_vec)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q      <= 1'b0;
            pend_tid_q  <= '0;
            match_valid <= 1'b0;
            match_tid   <= '0;
            done_valid  <= 1'b0;
            done_ok     <= 1'b0;
            done_tid    <= '0;
            done_kind   <= 1'b0;
            dup_err     <= 1'b0;
        end else begin
            dup_err     <= enq_dup;
            match_valid <= req_hit;
            if (req_hit) begin
                match_tid <= reply_tid;
            end
            if (reply_req_valid) begin
                pend_q     <= req_hit;
                pend_tid_q <= reply_tid;
            end else if (retire) begin
                pend_q <= 1'b0;
            end
            done_valid <= retire;
            if (retire) begin
                done_ok   <= rsp_is_success(reply_rsp_code);
                done_tid  <= pend_tid_q;
                done_kind <= kind_vec[pend_tid_q];
            end
        end
    end

    assign q_full  = &live_vec;
    assign q_empty = ~|live_vec;
endmodule

// File: rtl/dtq_tracker_chk.sv
module dtq_tracker_chk #(
    parameter int DEPTH      = 8,
    parameter int AGENT_ID_W = 4,
    localparam int TID_W     = $clog2(DEPTH),
    localparam int DEFID_W   = 1 + AGENT_ID_W + TID_W
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  own_agent_type,
    input logic [AGENT_ID_W-1:0] own_agent_id,
    input logic                  enq_valid,
    input logic [TID_W-1:0]      enq_tid,
    input logic                  reply_req_valid,
    input logic [DEFID_W-1:0]    reply_defid,
    input logic                  reply_rsp_valid,
    input logic                  match_valid,
    input logic [TID_W-1:0]      match_tid,
    input logic                  done_valid,
    input logic [TID_W-1:0]      done_tid,
    input logic                  dup_err,
    input logic [DEPTH-1:0]      live_vec,
    input logic                  pend_q
);
    logic [DEPTH-1:0] live_prev;
    logic             foreign;

    always_ff @(posedge clk) begin
        if (rst) live_prev <= '0;
        else     live_prev <= live_vec;
    end

    assign foreign = (reply_defid[DEFID_W-1] != own_agent_type) ||
                     (reply_defid[DEFID_W-2 -: AGENT_ID_W] != own_agent_id);

    p_enq_sets_live_r2: assert property (@(posedge clk) disable iff (rst)
        (enq_valid && !live_vec[enq_tid]) |=> live_vec[$past(enq_tid)]);

    p_dup_on_live_r3: assert property (@(posedge clk) disable iff (rst)
        dup_err |-> $past(live_vec[enq_tid]));

    p_match_was_live_r4: assert property (@(posedge clk) disable iff (rst)
        match_valid |-> live_prev[match_tid]);

    p_rsp_completes_r5: assert property (@(posedge clk) disable iff (rst)
        (reply_rsp_valid && pend_q) |=> done_valid);

    p_done_retired_r5: assert property (@(posedge clk) disable iff (rst)
        done_valid |-> !live_vec[done_tid]);

    p_foreign_ignored_r8: assert property (@(posedge clk) disable iff (rst)
        (reply_req_valid && foreign) |=> !match_valid);

    p_stray_rsp_r9: assert property (@(posedge clk) disable iff (rst)
        (reply_rsp_valid && !pend_q) |=> !done_valid);
endmodule

bind dtq_tracker dtq_tracker_chk #(.DEPTH(DEPTH), .AGENT_ID_W(AGENT_ID_W)) u_chk (
    .clk             (clk),
    .rst             (rst),
    .own_agent_type  (own_agent_type),
    .own_agent_id    (own_agent_id),
    .enq_valid       (enq_valid),
    .enq_tid         (enq_tid),
    .reply_req_valid (reply_req_valid),
    .reply_defid     (reply_defid),
    .reply_rsp_valid (reply_rsp_valid),
    .match_valid     (match_valid),
    .match_tid       (match_tid),
    .done_valid      (done_valid),
    .done_tid        (done_tid),
    .dup_err         (dup_err),
    .live_vec        (live_vec),
    .pend_q          (pend_q)
);

// File: tb/dtq_tracker_test.sv
`timescale 1ns/1ps
module dtq_tracker_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       own_agent_type = 1'b1;
    logic [3:0] own_agent_id = 4'h5;
    logic       enq_valid = 1'b0;
    logic [2:0] enq_tid = '0;
    logic       enq_kind = 1'b0;
    logic       reply_req_valid = 1'b0;
    logic [7:0] reply_defid = '0;
    logic       reply_rsp_valid = 1'b0;
    logic [1:0] reply_rsp_code = '0;
    logic       match_valid, done_valid, done_ok, done_kind, dup_err, q_full, q_empty;
    logic [2:0] match_tid, done_tid;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    dtq_tracker uut (
        .clk(clk), .rst(rst),
        .own_agent_type(own_agent_type), .own_agent_id(own_agent_id),
        .enq_valid(enq_valid), .enq_tid(enq_tid), .enq_kind(enq_kind),
        .reply_req_valid(reply_req_valid), .reply_defid(reply_defid),
        .reply_rsp_valid(reply_rsp_valid), .reply_rsp_code(reply_rsp_code),
        .match_valid(match_valid), .match_tid(match_tid),
        .done_valid(done_valid), .done_ok(done_ok), .done_tid(done_tid),
        .done_kind(done_kind), .dup_err(dup_err), .q_full(q_full), .q_empty(q_empty)
    );

    // op 0 = enqueue (id = tid), op 1 = reply (id = deferred-ID field)
    typedef struct packed {
        logic       op;
        logic [7:0] id;
        logic       kind;
        logic [1:0] code;
        logic       exp_hit;
        logic       exp_ok;
        logic       exp_kind;
    } vec_t;

    localparam int NVEC = 10;
    localparam vec_t VEC [NVEC] = '{
        '{1'b0, 8'h03, 1'b0, 2'b00, 1'b0, 1'b0, 1'b0},  // R2 enqueue tid3 write
        '{1'b0, 8'h05, 1'b1, 2'b00, 1'b0, 1'b0, 1'b0},  // R2 enqueue tid5 read
        '{1'b0, 8'h03, 1'b1, 2'b00, 1'b1, 1'b0, 1'b0},  // R3 duplicate tid3
        '{1'b1, 8'hAB, 1'b0, 2'b00, 1'b1, 1'b1, 1'b0},  // R4 R6 tid3 no-data, kind kept write
        '{1'b1, 8'hAB, 1'b0, 2'b00, 1'b0, 1'b0, 1'b0},  // R8 tid3 already retired
        '{1'b1, 8'h2D, 1'b0, 2'b00, 1'b0, 1'b0, 1'b0},  // R8 foreign agent type
        '{1'b1, 8'hBD, 1'b0, 2'b00, 1'b0, 1'b0, 1'b0},  // R8 foreign agent ID
        '{1'b1, 8'hAD, 1'b0, 2'b01, 1'b1, 1'b0, 1'b1},  // R7 tid5 hard failure
        '{1'b0, 8'h00, 1'b0, 2'b00, 1'b0, 1'b0, 1'b0},  // R2 enqueue tid0 write
        '{1'b1, 8'hA8, 1'b0, 2'b10, 1'b1, 1'b0, 1'b0}   // R7 tid0 other code
    };

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_enq(input logic [2:0] tid, input logic kind, input logic exp_dup, input string req);
        @(negedge clk);
        enq_valid = 1'b1; enq_tid = tid; enq_kind = kind;
        @(negedge clk);
        enq_valid = 1'b0;
        check({req, " dup_err"}, dup_err, exp_dup);
        check({req, " q_empty after enqueue"}, q_empty, 0);
    endtask

    task automatic do_reply(input logic [7:0] defid, input logic [1:0] code, input logic exp_hit,
                            input logic exp_ok, input logic exp_kind, input string req);
        @(negedge clk);
        reply_req_valid = 1'b1; reply_defid = defid;
        @(negedge clk);
        reply_req_valid = 1'b0;
        check({req, " match_valid"}, match_valid, exp_hit);
        if (exp_hit) check({req, " match_tid"}, match_tid, defid[2:0]);
        reply_rsp_valid = 1'b1; reply_rsp_code = code;
        @(negedge clk);
        reply_rsp_valid = 1'b0;
        check({req, " done_valid"}, done_valid, exp_hit);
        if (exp_hit) begin
            check({req, " done_tid"}, done_tid, defid[2:0]);
            check({req, " done_ok"}, done_ok, exp_ok);
            check({req, " done_kind"}, done_kind, exp_kind);
        end
    endtask

    task automatic stray_rsp(input string req);
        @(negedge clk);
        reply_rsp_valid = 1'b1; reply_rsp_code = 2'b00;
        @(negedge clk);
        reply_rsp_valid = 1'b0;
        check({req, " done_valid"}, done_valid, 0);
    endtask

    initial begin
        #(8 * 5000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1 q_empty", q_empty, 1);
        check("R1 q_full", q_full, 0);
        check("R1 match_valid", match_valid, 0);
        check("R1 done_valid", done_valid, 0);
        check("R1 dup_err", dup_err, 0);

        for (int i = 0; i < NVEC; i++) begin
            if (VEC[i].op == 1'b0)
                do_enq(VEC[i].id[2:0], VEC[i].kind, VEC[i].exp_hit, $sformatf("R2/R3 vec%0d", i));
            else
                do_reply(VEC[i].id, VEC[i].code, VEC[i].exp_hit, VEC[i].exp_ok, VEC[i].exp_kind,
                         $sformatf("R4-vector vec%0d", i));
        end
        check("R10 q_empty after drain", q_empty, 1);

        // R10 fill all entries; tid2 is a read
        for (int t = 0; t < 8; t++) begin
            do_enq(3'(t), (t == 2), 1'b0, "R2 fill");
            check("R10 q_full while filling", q_full, (t == 7));
        end
        // R3 duplicate while full
        do_enq(3'd2, 1'b0, 1'b1, "R3 dup when full");
        check("R3 q_full after dup", q_full, 1);
        // R9 response with no request
        stray_rsp("R9 stray response");
        check("R9 q_full unchanged", q_full, 1);
        // R8 foreign reply then its response
        do_reply(8'h2A, 2'b00, 1'b0, 1'b0, 1'b0, "R8 foreign reply");
        check("R8 q_full unchanged", q_full, 1);
        // R7 hard failure on tid2, original read kind kept (R3)
        do_reply(8'hAA, 2'b01, 1'b1, 1'b0, 1'b1, "R7 hard fail tid2");
        check("R10 q_full after retire", q_full, 0);
        check("R10 q_empty after retire", q_empty, 0);
        // R9 second response after retirement
        stray_rsp("R9 response after retire");

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule